// File: doc/BRIEF.md
# Read Termination Disable Window

This block works out when a DDR4 device has to switch off its on-die termination because it is driving read data itself. The memory controller gives it a strobe for every READ command. It also gives the programmed read latency, the read preamble mode (one or two clocks) and the CRC enable. The block then raises `odt_off_o` for the cycles in which the termination must stay released.

Two things set the window. The preamble mode decides how early the window opens. The preamble mode and the CRC setting together decide how long it lasts. A burst-chop 4 read uses the same window length as a BL8 read, so the block needs no burst-length input.

Reads that arrive close together can produce windows that overlap. These are merged into one continuous window. Self-refresh holds the termination off for as long as it lasts. The block also watches the spacing between reads: in two-clock preamble mode, a gap of exactly five clocks between two reads is not allowed, and the block reports it.

Top module: `rd_odt_gate`

## Requirements
- R1: With one-clock read preamble (`rd_pre2_i` = 0), a READ sampled at edge k drives `odt_off_o` high from just after edge k + RL − 2.
- R2: With two-clock read preamble (`rd_pre2_i` = 1), a READ sampled at edge k drives `odt_off_o` high from just after edge k + RL − 3.
- R3: A single window stays high for 4 + P + C consecutive cycles. P is 2 for one-clock preamble and 3 for two-clock preamble. Burst-chop 4 uses this same length.
- R4: C is 1 when `crc_en_i` = 1 and 0 otherwise, so enabling CRC makes the window one cycle longer.
- R5: When windows from several reads overlap or touch, `odt_off_o` stays high without a break until the window that ends last has ended.
- R6: While `self_ref_i` = 1, `odt_off_o` is 1 in the same cycle, whatever the read history.
- R7: With two-clock preamble, a READ sampled exactly 5 edges after the previous READ, with no READ in between, makes `spacing_err_o` high for the one cycle after that edge. Any other spacing leaves it low.
- R8: With one-clock preamble, `spacing_err_o` stays low for every read spacing, including a spacing of 5.
- R9: While reset is held, and just after it is released, `odt_off_o` and `spacing_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_cmd_i | input | 1 | One-cycle strobe for a READ command |
| rl_i | input | RL_W | Programmed read latency in clocks. Must be larger than the preamble offset |
| rd_pre2_i | input | 1 | Read preamble mode: 1 = two clocks, 0 = one clock |
| crc_en_i | input | 1 | CRC enable; makes the window one cycle longer |
| self_ref_i | input | 1 | High while the device is in self-refresh |
| odt_off_o | output | 1 | Termination must be off |
| spacing_err_o | output | 1 | One-cycle flag for an illegal read-to-read gap of 5 |

## Verification
The bench sweeps every combination of preamble mode and CRC over a range of read latencies. It checks every cycle of every window, so an off-by-one in the start offset, or in the P or C term, shows up as a window that is shifted or has the wrong length. Read pairs are tried at every gap from 1 to 10 clocks in all modes. A design that let an older window's countdown overwrite a newer one would drop `odt_off_o` too early. A design that tested only the gap and not the preamble mode would raise the spacing flag in one-clock mode. A self-refresh interval is laid over a read window, which catches a design that gates the termination off only through the read path.

// File: rtl/rd_odt_pkg.sv
package rd_odt_pkg;
  localparam int unsigned BURST_HALF = 4;  // BL8 timing, also used for chop-4
  localparam int unsigned PRE_SHORT  = 2;
  localparam int unsigned PRE_LONG   = 3;
  localparam int unsigned BAD_GAP    = 5;

  function automatic int unsigned pre_term(input logic pre2);
    return pre2 ? PRE_LONG : PRE_SHORT;
  endfunction

  function automatic int unsigned win_len(input logic pre2, input logic crc);
    return BURST_HALF + pre_term(pre2) + (crc ? 1 : 0);
  endfunction
endpackage

// File: rtl/odt_start_sched.sv
module odt_start_sched #(
  parameter int unsigned RL_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rd_i,
  input  logic [RL_W-1:0] rl_i,
  input  logic            pre2_i,
  output logic            start_o
);
  localparam int unsigned DEPTH = 1 << RL_W;

  logic [DEPTH-1:0] pend_q;
  logic [DEPTH-1:0] ins;
  logic [RL_W-1:0]  slot;

  // slot = (RL - preamble offset) - 1; bit 0 fires the window
  always_comb begin
    slot = rl_i - (pre2_i ? RL_W'(rd_odt_pkg::PRE_LONG + 1) : RL_W'(rd_odt_pkg::PRE_SHORT + 1));
    ins  = '0;
    if (rd_i) ins[slot] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q >> 1) | ins;
  end

  assign start_o = pend_q[0];

  p_rl_min_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |-> (32'(rl_i) > rd_odt_pkg::pre_term(pre2_i)));
endmodule

// File: rtl/odt_win_hold.sv
module odt_win_hold #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             win_o
);
  logic [CNT_W-1:0] left_q;
  logic [CNT_W-1:0] decr;
  logic [CNT_W-1:0] left_d;

  always_comb begin
    decr   = (left_q != '0) ? left_q - 1'b1 : '0;
    left_d = (start_i && len_i > decr) ? len_i : decr;  // merge: keep the later end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) left_q <= '0;
    else         left_q <= left_d;
  end

  assign win_o = (left_q != '0);

  p_open_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> win_o);
  p_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (left_q >= $past(len_i)));
  p_close_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(win_o) |-> !$past(start_i));
endmodule

// File: rtl/rd_gap_check.sv
module rd_gap_check #(
  parameter int unsigned GAP_W = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_i,
  input  logic pre2_i,
  output logic err_o
);
  logic [GAP_W-1:0] gap_q;
  logic             err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= rd_i && pre2_i && (gap_q == GAP_W'(rd_odt_pkg::BAD_GAP));
      if (rd_i)                           gap_q <= GAP_W'(1);
      else if (gap_q != '0 && gap_q != '1) gap_q <= gap_q + 1'b1;  // saturate
    end
  end

  assign err_o = err_q;

  p_err_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);
endmodule

// File: rtl/rd_odt_gate.sv
module rd_odt_gate #(
  parameter int unsigned RL_W  = 5,
  parameter int unsigned CNT_W = 4,
  parameter int unsigned GAP_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rd_cmd_i,
  input  logic [RL_W-1:0] rl_i,
  input  logic            rd_pre2_i,
  input  logic            crc_en_i,
  input  logic            self_ref_i,
  output logic            odt_off_o,
  output logic            spacing_err_o
);
  logic             start;
  logic             win;
  logic [CNT_W-1:0] len;

  assign len = CNT_W'(rd_odt_pkg::win_len(rd_pre2_i, crc_en_i));

  odt_start_sched #(.RL_W(RL_W)) i_sched (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_cmd_i),
    .rl_i(rl_i), .pre2_i(rd_pre2_i), .start_o(start)
  );

  odt_win_hold #(.CNT_W(CNT_W)) i_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start),
    .len_i(len), .win_o(win)
  );

  rd_gap_check #(.GAP_W(GAP_W)) i_gap (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_cmd_i),
    .pre2_i(rd_pre2_i), .err_o(spacing_err_o)
  );

  assign odt_off_o = win | self_ref_i;

  p_sr_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    self_ref_i |-> odt_off_o);
  p_err_mode_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spacing_err_o |-> $past(rd_pre2_i));
endmodule

// File: tb/test_rd_odt_gate.sv
`timescale 1ns/1ps
module test_rd_odt_gate;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rd_cmd_i = 1'b0;
  logic [4:0] rl_i = 5'd8;
  logic       rd_pre2_i = 1'b0;
  logic       crc_en_i = 1'b0;
  logic       self_ref_i = 1'b0;
  logic       odt_off_o;
  logic       spacing_err_o;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  rd_odt_gate i_rd_odt_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_cmd_i(rd_cmd_i), .rl_i(rl_i),
    .rd_pre2_i(rd_pre2_i), .crc_en_i(crc_en_i), .self_ref_i(self_ref_i),
    .odt_off_o(odt_off_o), .spacing_err_o(spacing_err_o)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic run(input logic p2, input logic crc, input int rl,
                     input logic [63:0] rdp, input logic [63:0] srp,
                     input int ncyc, input string tag);
    int d;
    int len;
    @(negedge clk_i);
    rst_ni = 1'b0; rd_cmd_i = 1'b0; self_ref_i = 1'b0;
    rd_pre2_i = p2; crc_en_i = crc; rl_i = 5'(rl);
    @(negedge clk_i);
    rst_ni = 1'b1;
    d   = rl - (p2 ? 3 : 2);
    len = 4 + (p2 ? 3 : 2) + (crc ? 1 : 0);
    for (int e = 0; e < ncyc; e++) begin
      logic eo;
      logic ee;
      @(negedge clk_i);
      rd_cmd_i   = rdp[e];
      self_ref_i = srp[e];
      @(posedge clk_i);
      #1;
      eo = srp[e];
      for (int k = 0; k <= e; k++)
        if (rdp[k] && e >= k + d && e <= k + d + len - 1) eo = 1'b1;
      ee = 1'b0;
      if (p2 && rdp[e] && e >= 5 && rdp[e-5] && rdp[e-4 +: 4] == 4'b0) ee = 1'b1;
      chk(odt_off_o, eo, {tag, " odt_off"});
      chk(spacing_err_o, ee, {tag, " spacing_err"});
    end
    @(negedge clk_i);
    rd_cmd_i = 1'b0; self_ref_i = 1'b0;
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R9: reset state
    repeat (2) @(negedge clk_i);
    chk(odt_off_o, 1'b0, "R9 reset odt_off");
    chk(spacing_err_o, 1'b0, "R9 reset spacing_err");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    chk(odt_off_o, 1'b0, "R9 post-reset odt_off");
    chk(spacing_err_o, 1'b0, "R9 post-reset spacing_err");

    // R1 R2 R3 R4: single reads over modes and latencies
    for (int p = 0; p < 2; p++)
      for (int c = 0; c < 2; c++)
        for (int rl = 5; rl <= 12; rl++)
          run(p[0], c[0], rl, 64'd1 << 2, 64'd0, rl + 14,
              p[0] ? "R2 R3 R4" : "R1 R3 R4");

    // R5 R7 R8: read pairs at gaps 1..10
    for (int p = 0; p < 2; p++)
      for (int c = 0; c < 2; c++)
        for (int g = 1; g <= 10; g++)
          run(p[0], c[0], 9, (64'd1 << 2) | (64'd1 << (2 + g)), 64'd0, 32,
              p[0] ? "R5 R7" : "R5 R8");

    // R7: triple with 5-gap after a shorter gap
    run(1'b1, 1'b0, 10, (64'd1 << 1) | (64'd1 << 3) | (64'd1 << 8), 64'd0, 30, "R7 R5");

    // R6: self-refresh alone and overlaid on a window
    run(1'b0, 1'b0, 8, 64'd0, 64'h1F0, 16, "R6");
    run(1'b1, 1'b1, 8, 64'd1 << 1, 64'h3C00, 24, "R6 R5");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule